// File: doc/BRIEF.md
# Link Error Logging and Report Gating

This block records link-layer error events for one port and decides which of them may be escalated. Two families of error events arrive as one-cycle pulses on parallel vectors: a 16-bit correctable family and a 32-bit uncorrectable family. An event is written into a sticky status vector unless its per-bit detect mask is set. Status bits stay set until software writes a one to the matching bit of a clear strobe. Each uncorrectable bit is classed as fatal or non-fatal by a per-bit severity vector. The block then rolls the logged bits up into three device-level category flags.

The block has a second mask layer, the report masks, which are separate from the detect masks. A report-masked bit is still logged, and it still raises its device category flag. It does not take part in the escalation request for its category. Each category (correctable, non-fatal, fatal) also has its own enable. A category request is raised only when that enable is on and at least one logged, unmasked bit of that category is present.

All event, mask and clear pins are plain control and status signals with no handshake. The block does not accept back-pressure: an event pulse is taken in the cycle it is presented, and nothing is queued. Category flags and requests follow from the registered status with no extra delay. A configuration change (severity, report mask, enable) therefore shows up in the same cycle.

Top module: `link_err_report`

## Requirements
- R1: A pulse on bit i of `cor_err_pulse` sets bit i of `cor_sts` at the next clock edge unless `cor_det_mask[i]` is 1; a masked pulse leaves the bit unchanged.
- R2: A pulse on bit i of `unc_err_pulse` sets bit i of `unc_sts` at the next clock edge unless `unc_det_mask[i]` is 1; a masked pulse leaves the bit unchanged.
- R3: Status bits are sticky. A bit clears at a clock edge only when its `cor_clr`/`unc_clr` bit is 1 (write-one-to-clear). Clear bits that are 0, and detect-mask changes made after logging, leave logged bits untouched.
- R4: When a new unmasked event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `unc_sev[i]` = 1 marks uncorrectable bit i as fatal and 0 marks it as non-fatal. `dev_fat` is 1 while any logged fatal-class bit is set, and `dev_nf` is 1 while any logged non-fatal-class bit is set. Both follow a change of `unc_sev` in the same cycle.
- R6: `dev_cor` is 1 exactly while any bit of `cor_sts` is set.
- R7: `cor_rpt_mask`/`unc_rpt_mask` bits do not stop logging or the device category flags. A report-masked bit does not contribute to its category request.
- R8: `req_cor`, `req_nf` and `req_fat` are each 1 only when their enable (`cor_rpt_en`, `nf_rpt_en`, `fat_rpt_en`) is 1 and at least one logged, report-unmasked bit of that category is set.
- R9: After an asynchronous active-low reset, both status vectors, all device flags and all requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cor_err_pulse | input | 16 | Correctable error event pulses, one bit per error type |
| unc_err_pulse | input | 32 | Uncorrectable error event pulses, one bit per error type |
| cor_det_mask | input | 16 | 1 = do not log this correctable error |
| unc_det_mask | input | 32 | 1 = do not log this uncorrectable error |
| cor_rpt_mask | input | 16 | 1 = logged correctable bit is not escalated |
| unc_rpt_mask | input | 32 | 1 = logged uncorrectable bit is not escalated |
| unc_sev | input | 32 | Per-bit class of uncorrectable errors: 1 fatal, 0 non-fatal |
| cor_clr | input | 16 | Write-one-to-clear strobe for the correctable status |
| unc_clr | input | 32 | Write-one-to-clear strobe for the uncorrectable status |
| cor_rpt_en | input | 1 | Enables the correctable category request |
| nf_rpt_en | input | 1 | Enables the non-fatal category request |
| fat_rpt_en | input | 1 | Enables the fatal category request |
| cor_sts | output | 16 | Sticky correctable status |
| unc_sts | output | 32 | Sticky uncorrectable status |
| dev_cor | output | 1 | Some correctable status bit is set |
| dev_nf | output | 1 | Some non-fatal uncorrectable status bit is set |
| dev_fat | output | 1 | Some fatal uncorrectable status bit is set |
| req_cor | output | 1 | Correctable escalation request |
| req_nf | output | 1 | Non-fatal escalation request |
| req_fat | output | 1 | Fatal escalation request |

## Verification
The properties compare each status vector with the event, mask and clear values of the previous cycle. They therefore assume those inputs hold known values, zero in practice, while reset is asserted and change only away from the rising edge. The bench holds every pulse and clear at zero through reset and drives all inputs on the falling edge. It asserts each pulse or clear for exactly one cycle, so every logged bit can be traced to a single edge. It changes severity, report masks and enables only between event cycles, so the same-cycle category checks see stable configuration.

// File: rtl/lerr_pkg.sv
package lerr_pkg;

  localparam int COR_W_DEF = 16;
  localparam int UNC_W_DEF = 32;
  localparam int N_CAT     = 3;

  // one flag per reporting category
  typedef struct packed {
    logic fat;
    logic nf;
    logic cor;
  } cat_t;

endpackage

// File: rtl/lerr_sticky_bank.sv
module lerr_sticky_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] det_mask,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sts
);

  localparam int LAST = W - 1;

  for (genvar i = 0; i <= LAST; i++) begin : g_bit
    logic q;
    logic set_now;

    assign set_now = evt[i] & ~det_mask[i];

    // a fresh event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (set_now) q <= 1'b1;
      else if (clr[i])  q <= 1'b0;
    end

    assign sts[i] = q;
  end

endmodule

// File: rtl/lerr_reduce.sv
module lerr_reduce #(
  parameter int W = 16
) (
  input  logic [W-1:0] vec,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] rpt_mask,
  output logic         any_log,
  output logic         any_pend
);

  logic [W-1:0] in_cat;
  logic [W-1:0] open_cat;

  assign in_cat   = vec & sel;
  assign open_cat = in_cat & ~rpt_mask;
  assign any_log  = |in_cat;
  assign any_pend = |open_cat;

endmodule

// File: rtl/lerr_cat_gate.sv
module lerr_cat_gate
  import lerr_pkg::*;
(
  input  cat_t logged,
  input  cat_t pend,
  input  cat_t en,
  output cat_t dev,
  output cat_t req
);

  assign dev = logged;
  assign req = cat_t'(pend & en);

endmodule

// File: rtl/link_err_report.sv
module link_err_report
  import lerr_pkg::*;
#(
  parameter int COR_W = COR_W_DEF,
  parameter int UNC_W = UNC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COR_W-1:0] cor_err_pulse,
  input  logic [UNC_W-1:0] unc_err_pulse,
  input  logic [COR_W-1:0] cor_det_mask,
  input  logic [UNC_W-1:0] unc_det_mask,
  input  logic [COR_W-1:0] cor_rpt_mask,
  input  logic [UNC_W-1:0] unc_rpt_mask,
  input  logic [UNC_W-1:0] unc_sev,
  input  logic [COR_W-1:0] cor_clr,
  input  logic [UNC_W-1:0] unc_clr,
  input  logic             cor_rpt_en,
  input  logic             nf_rpt_en,
  input  logic             fat_rpt_en,
  output logic [COR_W-1:0] cor_sts,
  output logic [UNC_W-1:0] unc_sts,
  output logic             dev_cor,
  output logic             dev_nf,
  output logic             dev_fat,
  output logic             req_cor,
  output logic             req_nf,
  output logic             req_fat
);

  localparam logic [COR_W-1:0] COR_ALL = '1;

  cat_t logged, pend, en, dev, req;

  lerr_sticky_bank #(.W(COR_W)) u_cor_bank (
    .clk(clk), .rst_n(rst_n), .evt(cor_err_pulse),
    .det_mask(cor_det_mask), .clr(cor_clr), .sts(cor_sts)
  );

  lerr_sticky_bank #(.W(UNC_W)) u_unc_bank (
    .clk(clk), .rst_n(rst_n), .evt(unc_err_pulse),
    .det_mask(unc_det_mask), .clr(unc_clr), .sts(unc_sts)
  );

  lerr_reduce #(.W(COR_W)) u_red_cor (
    .vec(cor_sts), .sel(COR_ALL), .rpt_mask(cor_rpt_mask),
    .any_log(logged.cor), .any_pend(pend.cor)
  );

  lerr_reduce #(.W(UNC_W)) u_red_fat (
    .vec(unc_sts), .sel(unc_sev), .rpt_mask(unc_rpt_mask),
    .any_log(logged.fat), .any_pend(pend.fat)
  );

  lerr_reduce #(.W(UNC_W)) u_red_nf (
    .vec(unc_sts), .sel(~unc_sev), .rpt_mask(unc_rpt_mask),
    .any_log(logged.nf), .any_pend(pend.nf)
  );

  assign en.cor = cor_rpt_en;
  assign en.nf  = nf_rpt_en;
  assign en.fat = fat_rpt_en;

  lerr_cat_gate u_gate (
    .logged(logged), .pend(pend), .en(en), .dev(dev), .req(req)
  );

  assign dev_cor = dev.cor;
  assign dev_nf  = dev.nf;
  assign dev_fat = dev.fat;
  assign req_cor = req.cor;
  assign req_nf  = req.nf;
  assign req_fat = req.fat;

endmodule

// File: rtl/link_err_report_chk.sv
module link_err_report_chk #(
  parameter int COR_W = 16,
  parameter int UNC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [COR_W-1:0] cor_err_pulse,
  input logic [UNC_W-1:0] unc_err_pulse,
  input logic [COR_W-1:0] cor_det_mask,
  input logic [UNC_W-1:0] unc_det_mask,
  input logic [COR_W-1:0] cor_clr,
  input logic [UNC_W-1:0] unc_clr,
  input logic             cor_rpt_en,
  input logic             nf_rpt_en,
  input logic             fat_rpt_en,
  input logic [COR_W-1:0] cor_sts,
  input logic [UNC_W-1:0] unc_sts,
  input logic             dev_cor,
  input logic             dev_nf,
  input logic             dev_fat,
  input logic             req_cor,
  input logic             req_nf,
  input logic             req_fat
);

  // R1 / R4: an unmasked event is always logged, even against a clear
  assert_cor_logged_R1: assert property (@(posedge clk) disable iff (!rst_n)
    |(cor_err_pulse & ~cor_det_mask) |=>
      ((cor_sts & $past(cor_err_pulse & ~cor_det_mask)) == $past(cor_err_pulse & ~cor_det_mask)));

  assert_cor_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cor_sts & ~$past(cor_sts) & ~$past(cor_err_pulse & ~cor_det_mask)) == '0));

  assert_unc_logged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |(unc_err_pulse & ~unc_det_mask) |=>
      ((unc_sts & $past(unc_err_pulse & ~unc_det_mask)) == $past(unc_err_pulse & ~unc_det_mask)));

  assert_unc_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((unc_sts & ~$past(unc_sts) & ~$past(unc_err_pulse & ~unc_det_mask)) == '0));

  assert_cor_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cor_sts & $past(cor_sts & ~cor_clr)) == '0));

  assert_unc_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~unc_sts & $past(unc_sts & ~unc_clr)) == '0));

  assert_cor_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cor_sts & $past(cor_clr & ~(cor_err_pulse & ~cor_det_mask))) == '0));

  assert_unc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((unc_sts & $past(unc_clr & ~(unc_err_pulse & ~unc_det_mask))) == '0));

  assert_fat_needs_log_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_fat |-> (unc_sts != '0));

  assert_nf_needs_log_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_nf |-> (unc_sts != '0));

  assert_dev_cor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_sts == '0) |-> !dev_cor);

  assert_req_cor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_cor |-> (dev_cor && cor_rpt_en));

  assert_req_nf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_nf |-> (dev_nf && nf_rpt_en));

  assert_req_fat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_fat |-> (dev_fat && fat_rpt_en));

endmodule

bind link_err_report link_err_report_chk #(.COR_W(COR_W), .UNC_W(UNC_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cor_err_pulse(cor_err_pulse), .unc_err_pulse(unc_err_pulse),
  .cor_det_mask(cor_det_mask), .unc_det_mask(unc_det_mask),
  .cor_clr(cor_clr), .unc_clr(unc_clr),
  .cor_rpt_en(cor_rpt_en), .nf_rpt_en(nf_rpt_en), .fat_rpt_en(fat_rpt_en),
  .cor_sts(cor_sts), .unc_sts(unc_sts),
  .dev_cor(dev_cor), .dev_nf(dev_nf), .dev_fat(dev_fat),
  .req_cor(req_cor), .req_nf(req_nf), .req_fat(req_fat)
);

// File: tb/sim_link_err_report.sv
`timescale 1ns/1ps
module sim_link_err_report;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cor_err_pulse = '0, cor_det_mask = '0, cor_rpt_mask = '0, cor_clr = '0;
  logic [31:0] unc_err_pulse = '0, unc_det_mask = '0, unc_rpt_mask = '0, unc_clr = '0;
  logic [31:0] unc_sev = '0;
  logic        cor_rpt_en = 1'b1, nf_rpt_en = 1'b1, fat_rpt_en = 1'b1;
  logic [15:0] cor_sts;
  logic [31:0] unc_sts;
  logic        dev_cor, dev_nf, dev_fat, req_cor, req_nf, req_fat;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  link_err_report u0 (
    .clk(clk), .rst_n(rst_n),
    .cor_err_pulse(cor_err_pulse), .unc_err_pulse(unc_err_pulse),
    .cor_det_mask(cor_det_mask), .unc_det_mask(unc_det_mask),
    .cor_rpt_mask(cor_rpt_mask), .unc_rpt_mask(unc_rpt_mask),
    .unc_sev(unc_sev), .cor_clr(cor_clr), .unc_clr(unc_clr),
    .cor_rpt_en(cor_rpt_en), .nf_rpt_en(nf_rpt_en), .fat_rpt_en(fat_rpt_en),
    .cor_sts(cor_sts), .unc_sts(unc_sts),
    .dev_cor(dev_cor), .dev_nf(dev_nf), .dev_fat(dev_fat),
    .req_cor(req_cor), .req_nf(req_nf), .req_fat(req_fat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one-cycle stimulus; returns on the falling edge after the capturing edge
  task automatic step(input logic [15:0] ce, input logic [31:0] ue,
                      input logic [15:0] cc, input logic [31:0] uc);
    @(negedge clk);
    cor_err_pulse = ce; unc_err_pulse = ue; cor_clr = cc; unc_clr = uc;
    @(negedge clk);
    cor_err_pulse = '0; unc_err_pulse = '0; cor_clr = '0; unc_clr = '0;
  endtask

  task automatic wipe();
    step('0, '0, '1, '1);
  endtask

  task automatic t_reset();
    chk("R9 cor_sts", 32'(cor_sts), 32'h0);
    chk("R9 unc_sts", unc_sts, 32'h0);
    chk("R9 dev flags", {29'h0, dev_fat, dev_nf, dev_cor}, 32'h0);
    chk("R9 requests", {29'h0, req_fat, req_nf, req_cor}, 32'h0);
  endtask

  task automatic t_cor_log();
    step(16'h0005, '0, '0, '0);
    chk("R1 cor logged", 32'(cor_sts), 32'h0005);
    chk("R6 dev_cor set", 32'(dev_cor), 32'h1);
    chk("R8 req_cor set", 32'(req_cor), 32'h1);
    wipe();
    chk("R6 dev_cor clear", 32'(dev_cor), 32'h0);
  endtask

  task automatic t_cor_detmask();
    cor_det_mask = 16'h0004;
    step(16'h0006, '0, '0, '0);
    chk("R1 cor det mask", 32'(cor_sts), 32'h0002);
    step(16'h0004, '0, '0, '0);
    chk("R1 masked only pulse", 32'(cor_sts), 32'h0002);
    cor_det_mask = '0;
    wipe();
  endtask

  task automatic t_unc_sev();
    unc_sev = 32'h8000_0010;
    step('0, 32'h0000_0010, '0, '0);
    chk("R2 unc logged", unc_sts, 32'h0000_0010);
    chk("R5 fatal class", {30'h0, dev_fat, dev_nf}, 32'h2);
    chk("R8 fatal request", {30'h0, req_fat, req_nf}, 32'h2);
    step('0, 32'h0000_0100, '0, '0);
    chk("R5 both classes", {30'h0, dev_fat, dev_nf}, 32'h3);
    @(negedge clk);
    unc_sev = 32'h0;
    #1;
    chk("R5 sev change", {30'h0, dev_fat, dev_nf}, 32'h1);
    unc_sev = '0;
    wipe();
  endtask

  task automatic t_unc_detmask();
    unc_det_mask = 32'hFFFF_0000;
    step('0, 32'h0001_0001, '0, '0);
    chk("R2 unc det mask", unc_sts, 32'h0000_0001);
    unc_det_mask = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R3 later det mask keeps bit", unc_sts, 32'h0000_0001);
    unc_det_mask = '0;
    wipe();
  endtask

  task automatic t_rptmask();
    unc_rpt_mask = 32'h0000_0001;
    step('0, 32'h0000_0001, '0, '0);
    chk("R7 masked still logged", unc_sts, 32'h0000_0001);
    chk("R7 nf dev set, no req", {30'h0, dev_nf, req_nf}, 32'h2);
    step('0, 32'h0000_0008, '0, '0);
    chk("R7 unmasked bit requests", 32'(req_nf), 32'h1);
    cor_rpt_mask = 16'hFFFF;
    step(16'h0200, '0, '0, '0);
    chk("R7 cor masked logged", 32'(cor_sts), 32'h0200);
    chk("R7 cor dev set, no req", {30'h0, dev_cor, req_cor}, 32'h2);
    cor_rpt_mask = '0; unc_rpt_mask = '0;
    wipe();
  endtask

  task automatic t_enable();
    nf_rpt_en = 1'b0;
    step('0, 32'h0000_0040, '0, '0);
    chk("R8 nf disabled", {30'h0, dev_nf, req_nf}, 32'h2);
    @(negedge clk);
    nf_rpt_en = 1'b1;
    #1;
    chk("R8 nf enabled", 32'(req_nf), 32'h1);
    cor_rpt_en = 1'b0;
    step(16'h0001, '0, '0, '0);
    chk("R8 cor disabled", 32'(req_cor), 32'h0);
    cor_rpt_en = 1'b1;
    wipe();
  endtask

  task automatic t_clear();
    step(16'h00F0, 32'hA000_0000, '0, '0);
    step('0, '0, 16'h0030, 32'h2000_0000);
    chk("R3 partial clear cor", 32'(cor_sts), 32'h00C0);
    chk("R3 partial clear unc", unc_sts, 32'h8000_0000);
    step('0, '0, '0, '0);
    chk("R3 sticky hold", 32'(cor_sts), 32'h00C0);
  endtask

  task automatic t_collide();
    step(16'h0040, 32'h8000_0000, 16'h00C0, 32'h8000_0000);
    chk("R4 cor set wins", 32'(cor_sts), 32'h0040);
    chk("R4 unc set wins", unc_sts, 32'h8000_0000);
    wipe();
    chk("R3 full clear", 32'(cor_sts) | unc_sts, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cor_log();
    t_cor_detmask();
    t_unc_sev();
    t_unc_detmask();
    t_rptmask();
    t_enable();
    t_clear();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule